// File: doc/BRIEF.md
# Power Monitor Two-Wire Slave Port

This block is the serial control port of a supply power monitor. It sits on a two-wire bus as a slave with a seven-bit address. The upper five address bits are fixed and two strap inputs supply the rest, so four monitors can share one bus. SCL and SDA are oversampled on the system clock. The block finds START and STOP conditions, shifts bytes in and out MSB first, and drives acknowledge bits through an open-drain pull-down output.

A bus master writes a seven-bit command word that picks the conversion mode and the readback format. It also writes three configuration registers: alert enable, alert threshold and control. On a read, the port returns the latest 12-bit voltage and current results from the conversion sequencer. These are packed into two or three bytes according to the selected mode. A command flag can instead make reads return a status byte. A read request is refused while a one-shot conversion is still in progress, and the address is NACKed.

Top module: `pmon_i2c_slave`

## Requirements
- R1: After reset the command word is 0, alert enable is 0x04, alert threshold is 0xFF, control is 0x00 and SDA is released (pull output low).
- R2: The slave address is {5'b01011, strap[1:0]}, sent MSB first and followed by the direction bit (0 = write, 1 = read). A matching write address is ACKed by pulling SDA low during the ninth clock. A mismatched address leaves SDA released for the rest of the transfer.
- R3: A write that carries only the address and then a STOP is ACKed and changes no register.
- R4: In a write, a first data byte with bit 7 = 0 loads its bits 6:0 into the command word, and the byte is ACKed.
- R5: In a write, a first data byte with bit 7 = 1 selects a configuration register by its bits 1:0 (01 alert enable, 10 alert threshold, 11 control). The following byte is stored there. Selector 00 stores nothing.
- R6: When a voltage mode (command bit 0 or 1) and a current mode (command bit 2 or 3) are both set, a read returns V[11:4], then I[11:4], then {V[3:0], I[3:0]}.
- R7: When only current modes are set, a read returns I[11:4] then {I[3:0], 4'b0000}. In every other non-status case it returns the voltage in the same two-byte form.
- R8: When command bit 6 is set, every byte of a read is the status input.
- R9: A read address is NACKed, and SDA stays released, while the one-shot busy input is high.
- R10: After the master NACKs a read byte, the slave drives SDA no more until the next START.
- R11: A START or STOP in the middle of a byte abandons the transfer without any register write. After a START the next byte is treated as a fresh address.
- R12: Read bytes past the packed length of the current format return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap_i | input | 2 | Low two address bits |
| oneshot_busy_i | input | 1 | A requested single conversion is not yet done |
| volt_i | input | 12 | Latest voltage result |
| curr_i | input | 12 | Latest current result |
| status_i | input | 8 | Status byte from the alert logic |
| cmd_o | output | 7 | Command word |
| alert_en_o | output | 8 | Alert enable register |
| alert_th_o | output | 8 | Alert threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
The assertions assume the master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume each SCL phase lasts longer than the synchronizer delay, so every edge is seen once. The bench keeps every SCL quarter period at ten clock cycles and changes SDA only in the low phase. It forms START and STOP only when the slave has released the line: after a write-phase acknowledge or after a master NACK. The mid-byte START and STOP cases are placed inside write bytes, where the slave never drives.

// File: rtl/pmon_i2c_pkg.sv
// Shared types and constants for the power monitor serial port.
package pmon_i2c_pkg;
    localparam int SAMPLE_W = 12;
    localparam int BYTE_W   = 8;
    localparam int CMD_W    = 7;
    localparam logic [4:0] ADDR_PREFIX = 5'b01011;

    // Selector codes for the configuration registers.
    localparam logic [1:0] SEL_AEN = 2'b01;
    localparam logic [1:0] SEL_THR = 2'b10;
    localparam logic [1:0] SEL_CTL = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_WR_BYTE,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_NEXT
    } link_state_e;
endpackage

// File: rtl/pmon_line_sampler.sv
// Synchronizes SCL and SDA into the clock domain and flags SCL edges and
// START/STOP conditions. Assumes each bus phase outlasts SYNC_STAGES + 1 clocks.
module pmon_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;
    logic scl_s;

    // Synchronizer chains plus one history stage; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
    end
endmodule

// File: rtl/pmon_reg_bank.sv
// Holds the command word and the three configuration registers.
// Assumes at most one write strobe per cycle; selector 00 is discarded.
module pmon_reg_bank
    import pmon_i2c_pkg::*;
#(
    parameter int          REG_W   = 8,
    parameter logic [7:0]  AEN_RST = 8'h04,
    parameter logic [7:0]  THR_RST = 8'hFF,
    parameter logic [7:0]  CTL_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             ext_we,
    input  logic [1:0]       ext_sel,
    input  logic [REG_W-1:0] ext_wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic [REG_W-1:0] aen_q,
    output logic [REG_W-1:0] thr_q,
    output logic [REG_W-1:0] ctl_q
);
    // Command word update.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= cmd_wdata;
    end

    // Configuration register update by selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aen_q <= AEN_RST[REG_W-1:0];
            thr_q <= THR_RST[REG_W-1:0];
            ctl_q <= CTL_RST[REG_W-1:0];
        end else if (ext_we) begin
            case (ext_sel)
                SEL_AEN: aen_q <= ext_wdata;
                SEL_THR: thr_q <= ext_wdata;
                SEL_CTL: ctl_q <= ext_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmon_read_packer.sv
// Chooses the byte to return for a read from the mode bits and byte index.
// Purely combinational; results are taken live when each byte is loaded.
module pmon_read_packer
    import pmon_i2c_pkg::*;
(
    input  logic [1:0]          volt_modes,
    input  logic [1:0]          curr_modes,
    input  logic                status_sel,
    input  logic [1:0]          byte_idx,
    input  logic [SAMPLE_W-1:0] volt_i,
    input  logic [SAMPLE_W-1:0] curr_i,
    input  logic [BYTE_W-1:0]   status_i,
    output logic [BYTE_W-1:0]   byte_o
);
    localparam int LO_W = SAMPLE_W - BYTE_W;

    logic v_on;
    logic i_on;
    logic [SAMPLE_W-1:0] single;

    // Byte selection by format and position.
    always_comb begin
        v_on   = |volt_modes;
        i_on   = |curr_modes;
        single = (i_on && !v_on) ? curr_i : volt_i;
        byte_o = '0;
        if (status_sel) begin
            byte_o = status_i;
        end else if (v_on && i_on) begin
            case (byte_idx)
                2'd0:    byte_o = volt_i[SAMPLE_W-1:LO_W];
                2'd1:    byte_o = curr_i[SAMPLE_W-1:LO_W];
                2'd2:    byte_o = {volt_i[LO_W-1:0], curr_i[LO_W-1:0]};
                default: byte_o = '0;
            endcase
        end else begin
            case (byte_idx)
                2'd0:    byte_o = single[SAMPLE_W-1:LO_W];
                2'd1:    byte_o = {single[LO_W-1:0], {(BYTE_W-LO_W){1'b0}}};
                default: byte_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmon_i2c_slave.sv
// Two-wire slave port of the power monitor. Matches its address, accepts
// command and configuration writes, and serves packed readback or status.
// Assumes SDA changes only while SCL is low except at START/STOP.
module pmon_i2c_slave
    import pmon_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    input  logic [1:0]          addr_strap_i,
    input  logic                oneshot_busy_i,
    input  logic [SAMPLE_W-1:0] volt_i,
    input  logic [SAMPLE_W-1:0] curr_i,
    input  logic [BYTE_W-1:0]   status_i,
    output logic [CMD_W-1:0]    cmd_o,
    output logic [BYTE_W-1:0]   alert_en_o,
    output logic [BYTE_W-1:0]   alert_th_o,
    output logic [BYTE_W-1:0]   ctrl_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    link_state_e         state;
    logic [2:0]          bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rd_dir;
    logic                ack_drive;
    logic [1:0]          byte_idx;
    logic                ext_pending;
    logic [1:0]          ext_sel_q;
    logic [BYTE_W-1:0]   rd_byte;
    logic [BYTE_W-1:0]   in_byte;
    logic                byte_done;
    logic                cmd_we;
    logic                ext_we;
    logic [6:0]          my_addr;

    pmon_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pmon_read_packer u_pack (
        .volt_modes (cmd_o[1:0]),
        .curr_modes (cmd_o[3:2]),
        .status_sel (cmd_o[6]),
        .byte_idx   (byte_idx),
        .volt_i     (volt_i),
        .curr_i     (curr_i),
        .status_i   (status_i),
        .byte_o     (rd_byte)
    );

    // Write decode of the byte completing on this SCL rise.
    always_comb begin
        my_addr   = {ADDR_PREFIX, addr_strap_i};
        in_byte   = {shreg[BYTE_W-2:0], sda_s};
        byte_done = scl_rise && (bit_cnt == 3'd7) && !start_det && !stop_det;
        cmd_we    = (state == ST_WR_BYTE) && byte_done && (byte_idx == 2'd0) && !in_byte[7];
        ext_we    = (state == ST_WR_BYTE) && byte_done && (byte_idx == 2'd1) && ext_pending;
    end

    pmon_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (in_byte[CMD_W-1:0]),
        .ext_we    (ext_we),
        .ext_sel   (ext_sel_q),
        .ext_wdata (in_byte),
        .cmd_q     (cmd_o),
        .aen_q     (alert_en_o),
        .thr_q     (alert_th_o),
        .ctl_q     (ctrl_o)
    );

    // Bus protocol sequencer: address, acknowledge, write and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            rd_dir      <= 1'b0;
            ack_drive   <= 1'b0;
            byte_idx    <= '0;
            ext_pending <= 1'b0;
            ext_sel_q   <= '0;
            sda_pull_o  <= 1'b0;
        end else if (start_det) begin
            state       <= ST_ADDR;
            bit_cnt     <= '0;
            byte_idx    <= '0;
            ext_pending <= 1'b0;
            sda_pull_o  <= 1'b0;
        end else if (stop_det) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (scl_rise) begin
                    shreg   <= in_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        state     <= ST_ACK_SET;
                        rd_dir    <= sda_s;
                        ack_drive <= (shreg[6:0] == my_addr) && !(sda_s && oneshot_busy_i);
                    end
                end
                ST_ACK_SET: if (scl_fall) begin
                    if (ack_drive) begin
                        sda_pull_o <= 1'b1;
                        state      <= ST_ACK_HOLD;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ACK_HOLD: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (rd_dir) begin
                        shreg      <= rd_byte;
                        sda_pull_o <= !rd_byte[BYTE_W-1];
                        state      <= ST_RD_BYTE;
                    end else begin
                        sda_pull_o <= 1'b0;
                        state      <= ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: if (scl_rise) begin
                    shreg   <= in_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        state     <= ST_ACK_SET;
                        ack_drive <= 1'b1;
                        if (byte_idx == 2'd0) begin
                            ext_pending <= in_byte[7];
                            ext_sel_q   <= in_byte[1:0];
                        end
                        if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                    end
                end
                ST_RD_BYTE: if (scl_fall) begin
                    if (bit_cnt == 3'd7) begin
                        sda_pull_o <= 1'b0;
                        state      <= ST_RD_ACK;
                    end else begin
                        bit_cnt    <= bit_cnt + 3'd1;
                        shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= !shreg[BYTE_W-2];
                    end
                end
                ST_RD_ACK: if (scl_rise) begin
                    if (sda_s) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_RD_NEXT;
                        if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                    end
                end
                ST_RD_NEXT: if (scl_fall) begin
                    bit_cnt    <= '0;
                    shreg      <= rd_byte;
                    sda_pull_o <= !rd_byte[BYTE_W-1];
                    state      <= ST_RD_BYTE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmon_i2c_slave_chk.sv
// Protocol checker attached to the serial port by bind.
module pmon_i2c_slave_chk
    import pmon_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_rise,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_pull_o,
    input logic [CMD_W-1:0] cmd_o,
    input logic [7:0]       alert_th_o
);
    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (cmd_o == '0 && alert_th_o == 8'hFF && !sda_pull_o));

    // R2: the pull-down only engages just after SCL has fallen.
    assert_pull_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    assert_start_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o);

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    assert_cmd_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> $past(scl_rise));

    assert_thr_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alert_th_o) |-> $past(scl_rise));
endmodule

bind pmon_i2c_slave pmon_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .cmd_o      (cmd_o),
    .alert_th_o (alert_th_o)
);

// File: tb/pmon_i2c_slave_tb.sv
module pmon_i2c_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [1:0]  strap = 2'b10;
    logic        busy = 1'b0;
    logic [11:0] volt = 12'hABC;
    logic [11:0] curr = 12'h123;
    logic [7:0]  status = 8'h5A;
    logic [6:0]  cmd;
    logic [7:0]  aen, thr, ctl;

    localparam int Q = 10;
    localparam logic [6:0] MY_ADDR = {5'b01011, 2'b10};

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    pmon_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .addr_strap_i(strap), .oneshot_busy_i(busy),
        .volt_i(volt), .curr_i(curr), .status_i(status), .cmd_o(cmd),
        .alert_en_o(aen), .alert_th_o(thr), .ctrl_o(ctl)
    );

    typedef struct { string tag; int unsigned val; } item_t;
    item_t exp_q[$];
    int unsigned obs_q[$];
    int n_cmp = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Driver side of the scoreboard: expected first, then the observation.
    task automatic chk(string tag, int unsigned expv, int unsigned act);
        exp_q.push_back('{tag: tag, val: expv});
        obs_q.push_back(act);
    endtask

    // Monitor: pops observations and compares with the expected queue.
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            begin
                int unsigned a;
                item_t e;
                a = obs_q.pop_front();
                e = exp_q.pop_front();
                n_cmp++;
                if (a != e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic qwait(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask
    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    endtask
    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_line; qwait(); scl_m = 1'b0; qwait();
    endtask
    task automatic wr_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask
    task automatic rd_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nack);
    endtask
    task automatic write2(string tag, input logic [7:0] b0, input logic [7:0] b1, input bit two);
        logic a;
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk(tag, 0, a);
        wr_byte(b0, a); chk(tag, 0, a);
        if (two) begin wr_byte(b1, a); chk(tag, 0, a); end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 cmd", 0, cmd);
        chk("R1 aen", 8'h04, aen);
        chk("R1 thr", 8'hFF, thr);
        chk("R1 ctl", 8'h00, ctl);
        chk("R1 sda", 0, sda_pull);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: foreign address is not acknowledged, line stays released
        bus_start();
        wr_byte({7'b0101100, 1'b0}, a); chk("R2 foreign ack", 1, a);
        wr_byte(8'h05, a); chk("R2 foreign released", 1, a);
        bus_stop();
        chk("R2 cmd untouched", 0, cmd);

        // R3: quick command
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R3 quick ack", 0, a);
        bus_stop();
        chk("R3 cmd", 0, cmd);
        chk("R3 thr", 8'hFF, thr);

        // R4: command byte write, both channels
        write2("R4 ack", 8'h05, 8'h00, 1'b0);
        chk("R4 cmd", 7'h05, cmd);

        // R6: three-byte read, then R12 extra byte
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, a); chk("R6 addr ack", 0, a);
        rd_byte(1'b0, d); chk("R6 byte0", 8'hAB, d);
        rd_byte(1'b0, d); chk("R6 byte1", 8'h12, d);
        rd_byte(1'b0, d); chk("R6 byte2", 8'hC3, d);
        rd_byte(1'b1, d); chk("R12 past end", 8'h00, d);
        // R10: after NACK, no more driving
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        chk("R10 released", 8'hFF, d);
        bus_stop();

        // R7: voltage only
        write2("R7 ack", 8'h01, 8'h00, 1'b0);
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, a);
        rd_byte(1'b0, d); chk("R7 v hi", 8'hAB, d);
        rd_byte(1'b0, d); chk("R7 v lo", 8'hC0, d);
        rd_byte(1'b1, d); chk("R12 two-byte end", 8'h00, d);
        bus_stop();

        // R7: current only
        write2("R7 ack", 8'h08, 8'h00, 1'b0);
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, a);
        rd_byte(1'b0, d); chk("R7 i hi", 8'h12, d);
        rd_byte(1'b1, d); chk("R7 i lo", 8'h30, d);
        bus_stop();

        // R8: status read
        write2("R8 ack", 8'h45, 8'h00, 1'b0);
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, a);
        rd_byte(1'b0, d); chk("R8 status0", 8'h5A, d);
        rd_byte(1'b1, d); chk("R8 status1", 8'h5A, d);
        bus_stop();

        // R9: busy refuses the read
        busy = 1'b1;
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, a); chk("R9 nack", 1, a);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        chk("R9 released", 8'hFF, d);
        bus_stop();
        busy = 1'b0;

        // R5: configuration writes
        write2("R5 ack", 8'h81, 8'h3C, 1'b1);
        chk("R5 aen", 8'h3C, aen);
        write2("R5 ack", 8'h82, 8'h77, 1'b1);
        chk("R5 thr", 8'h77, thr);
        write2("R5 ack", 8'h83, 8'h01, 1'b1);
        chk("R5 ctl", 8'h01, ctl);
        write2("R5 ack", 8'h80, 8'h99, 1'b1);
        chk("R5 sel00 aen", 8'h3C, aen);
        chk("R5 sel00 thr", 8'h77, thr);
        chk("R5 sel00 ctl", 8'h01, ctl);
        chk("R5 sel00 cmd", 7'h45, cmd);

        // R11: STOP in the middle of a data byte
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, a);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R11 stop abort cmd", 7'h45, cmd);

        // R11: START in the middle, then a fresh address and command
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, a); chk("R11 restart ack", 0, a);
        wr_byte(8'h02, a); chk("R11 restart data ack", 0, a);
        bus_stop();
        chk("R11 restart cmd", 7'h02, cmd);

        repeat (20) @(negedge clk);
        wait (obs_q.size() == 0);
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule